// File: doc/BRIEF.md
# Signed Integer Divide Coprocessor

This block is a register-mapped signed integer divider that a processor attaches to as a peripheral. Software writes a 64-bit dividend and a 64-bit divisor as 32-bit halves, and picks one of three operand-width modes with the two low bits of a control word. Any write to an operand half or to the control word starts a division. While the division runs, the control word shows a busy flag. When the result is ready, busy clears and a 64-bit quotient and a 64-bit remainder can be read back as 32-bit halves.

The datapath is a serial restoring divider. It works on magnitudes, one quotient bit per clock, and the signs are fixed up afterwards. Two operand combinations have fixed results and raise an error flag:

- a divisor whose effective value is zero;
- the most negative 64-bit dividend divided by minus one.

A write to an operand or to the control word during a division abandons that division and starts again with the new values.

Top module: `sdiv_coproc`

## Requirements
- R1: Control bits [1:0] select the mode. With 0, both operands are the sign extension of their low 32 bits. With 1 or 3, the dividend is used at 64 bits and the divisor is the sign extension of its low 32 bits. With 2, both operands are used at 64 bits.
- R2: Control bit 15 reads 1 from the cycle after a starting write until the result has been stored, and reads 0 from then on. Writes to bit 15 have no effect.
- R3: Control bit 14 is set by a zero divisor and by the overflow case. It is cleared by every division that completes normally. Writes to bit 14 have no effect.
- R4: When the effective divisor is zero, the remainder becomes the effective dividend. The quotient becomes 1 if the dividend is negative and 0 if it is not.
- R5: When the effective dividend is 0x8000_0000_0000_0000 and the effective divisor is -1, the quotient becomes the dividend and the remainder keeps its previous value. A 32-bit minimum divided by -1 in mode 0 is a normal division with quotient 0x8000_0000 and remainder 0.
- R6: A normal division truncates the quotient toward zero, and the remainder has the sign of the dividend.
- R7: Word addresses are 0 control, 1/2 dividend low/high, 3/4 divisor low/high, 5/6 quotient low/high, 7/8 remainder low/high. Each 64-bit value is split with the low 32 bits at the lower address. Operands read back as written.
- R8: A write to address 0 to 4 during a division restarts it, and only the result for the final operand values is stored.
- R9: Writes to addresses 5 to 15 have no effect. They start nothing and change no readable register, and unused addresses read 0.
- R10: Busy reads 1 for exactly DIV_W+2 cycles after the starting write, which is 66 cycles at the default width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears every register |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 4 | Word address for both the write and the read |
| wdata | input | DIV_W/2 | Write data |
| rdata | output | DIV_W/2 | Read data of the addressed word (combinational) |

## Verification
The assertions check on every cycle that:

- a starting write raises busy;
- the serial counter reloads on a restart and counts down one step per cycle;
- every partial remainder at completion is below the divisor;
- results stay frozen while the unit is idle;
- the zero-divisor and overflow captures store the dividend or hold the old remainder.

Only the bench scenarios can show the arithmetic itself. These are the results of each mode against a reference model, the sign rules, the exact busy length, restart behaviour, and that writes to result addresses are ignored.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_NUM_LO = 4'd1;
    localparam logic [ADDR_W-1:0] A_NUM_HI = 4'd2;
    localparam logic [ADDR_W-1:0] A_DEN_LO = 4'd3;
    localparam logic [ADDR_W-1:0] A_DEN_HI = 4'd4;
    localparam logic [ADDR_W-1:0] A_QUO_LO = 4'd5;
    localparam logic [ADDR_W-1:0] A_QUO_HI = 4'd6;
    localparam logic [ADDR_W-1:0] A_REM_LO = 4'd7;
    localparam logic [ADDR_W-1:0] A_REM_HI = 4'd8;

    localparam int BUSY_BIT = 15;
    localparam int ERR_BIT  = 14;

    // mode codes: 0 both narrow, 2 both wide, 1 and 3 wide dividend / narrow divisor
    localparam logic [1:0] MODE_NARROW = 2'd0;
    localparam logic [1:0] MODE_WIDE   = 2'd2;
endpackage

// File: rtl/sdiv_operand_prep.sv
module sdiv_operand_prep
    import sdiv_pkg::*;
#(
    parameter int DIV_W = 64
) (
    input  logic [1:0]       mode,
    input  logic [DIV_W-1:0] num_raw,
    input  logic [DIV_W-1:0] den_raw,
    output logic [DIV_W-1:0] num_eff,
    output logic [DIV_W-1:0] num_mag,
    output logic [DIV_W-1:0] den_mag,
    output logic             num_neg,
    output logic             den_neg,
    output logic             den_zero,
    output logic             ovf
);
    localparam int HALF = DIV_W / 2;
    localparam logic [DIV_W-1:0] MOST_NEG = {1'b1, {(DIV_W-1){1'b0}}};

    logic [DIV_W-1:0] den_eff;

    always_comb begin
        if (mode == MODE_NARROW)
            num_eff = {{HALF{num_raw[HALF-1]}}, num_raw[HALF-1:0]};
        else
            num_eff = num_raw;
        if (mode == MODE_WIDE)
            den_eff = den_raw;
        else
            den_eff = {{HALF{den_raw[HALF-1]}}, den_raw[HALF-1:0]};

        num_neg  = num_eff[DIV_W-1];
        den_neg  = den_eff[DIV_W-1];
        num_mag  = num_neg ? (~num_eff + 1'b1) : num_eff;
        den_mag  = den_neg ? (~den_eff + 1'b1) : den_eff;
        den_zero = (den_eff == '0);
        ovf      = (num_eff == MOST_NEG) && (den_eff == '1);
    end
endmodule

// File: rtl/sdiv_restore_engine.sv
module sdiv_restore_engine #(
    parameter int DIV_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] num_mag,
    input  logic [DIV_W-1:0] den_mag,
    output logic             done,
    output logic [DIV_W-1:0] quo_mag,
    output logic [DIV_W-1:0] rem_mag
);
    localparam int CNT_W = $clog2(DIV_W + 1);

    typedef struct packed {
        logic             active;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [DIV_W:0]   part;
        logic [DIV_W-1:0] quo;
        logic [DIV_W-1:0] dvs;
    } eng_t;

    eng_t q, d;
    logic [DIV_W:0] shifted;
    logic [DIV_W:0] trial;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        shifted = {q.part[DIV_W-1:0], q.quo[DIV_W-1]};
        trial   = shifted - {1'b0, q.dvs};
        if (start) begin
            d.active = 1'b1;
            d.cnt    = CNT_W'(DIV_W);
            d.part   = '0;
            d.quo    = num_mag;
            d.dvs    = den_mag;
        end else if (q.active) begin
            if (!trial[DIV_W]) begin
                d.part = trial;
                d.quo  = {q.quo[DIV_W-2:0], 1'b1};
            end else begin
                d.part = shifted;
                d.quo  = {q.quo[DIV_W-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.active = 1'b0;
                d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done    = q.done;
    assign quo_mag = q.quo;
    assign rem_mag = q.part[DIV_W-1:0];

    // R8: a start always reloads the full step count
    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (q.active && q.cnt == CNT_W'(DIV_W)));

    // R10: one step per cycle while running
    p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && !start) |=> (q.cnt == $past(q.cnt) - 1'b1));

    // R6: the final partial remainder is below the divisor
    p_rem_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.dvs != '0) |-> (q.part[DIV_W-1:0] < q.dvs));
endmodule

// File: rtl/sdiv_result_fix.sv
module sdiv_result_fix #(
    parameter int DIV_W = 64
) (
    input  logic [DIV_W-1:0] num_eff,
    input  logic [DIV_W-1:0] quo_mag,
    input  logic [DIV_W-1:0] rem_mag,
    input  logic             num_neg,
    input  logic             den_neg,
    input  logic             den_zero,
    input  logic             ovf,
    input  logic [DIV_W-1:0] rem_prev,
    output logic [DIV_W-1:0] quo_out,
    output logic [DIV_W-1:0] rem_out,
    output logic             err_out
);
    always_comb begin
        if (den_zero) begin
            quo_out = {{(DIV_W-1){1'b0}}, num_neg};
            rem_out = num_eff;
            err_out = 1'b1;
        end else if (ovf) begin
            quo_out = num_eff;
            rem_out = rem_prev;
            err_out = 1'b1;
        end else begin
            quo_out = (num_neg ^ den_neg) ? (~quo_mag + 1'b1) : quo_mag;
            rem_out = num_neg ? (~rem_mag + 1'b1) : rem_mag;
            err_out = 1'b0;
        end
    end
endmodule

// File: rtl/sdiv_coproc.sv
module sdiv_coproc
    import sdiv_pkg::*;
#(
    parameter int DIV_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DIV_W/2-1:0]   wdata,
    output logic [DIV_W/2-1:0]   rdata
);
    localparam int BUS_W = DIV_W / 2;

    typedef struct packed {
        logic [1:0]       mode;
        logic             busy;
        logic             err;
        logic             start;
        logic [DIV_W-1:0] num;
        logic [DIV_W-1:0] den;
        logic [DIV_W-1:0] quo;
        logic [DIV_W-1:0] rem;
    } regs_t;

    regs_t q, d;

    logic [DIV_W-1:0] num_eff, num_mag, den_mag, quo_mag, rem_mag;
    logic [DIV_W-1:0] res_quo, res_rem;
    logic             num_neg, den_neg, den_zero, ovf, res_err, eng_done;
    logic             wr_start, accept;
    logic [BUS_W-1:0] ctrl_word;

    sdiv_operand_prep #(.DIV_W(DIV_W)) u_prep (
        .mode(q.mode), .num_raw(q.num), .den_raw(q.den),
        .num_eff(num_eff), .num_mag(num_mag), .den_mag(den_mag),
        .num_neg(num_neg), .den_neg(den_neg), .den_zero(den_zero), .ovf(ovf)
    );

    sdiv_restore_engine #(.DIV_W(DIV_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(q.start),
        .num_mag(num_mag), .den_mag(den_mag),
        .done(eng_done), .quo_mag(quo_mag), .rem_mag(rem_mag)
    );

    sdiv_result_fix #(.DIV_W(DIV_W)) u_fix (
        .num_eff(num_eff), .quo_mag(quo_mag), .rem_mag(rem_mag),
        .num_neg(num_neg), .den_neg(den_neg), .den_zero(den_zero), .ovf(ovf),
        .rem_prev(q.rem), .quo_out(res_quo), .rem_out(res_rem), .err_out(res_err)
    );

    always_comb begin
        d        = q;
        d.start  = 1'b0;
        wr_start = wr_en && (addr <= A_DEN_HI);
        accept   = eng_done && q.busy && !q.start && !wr_start;
        if (wr_en) begin
            case (addr)
                A_CTRL:   d.mode = wdata[1:0];
                A_NUM_LO: d.num[BUS_W-1:0]     = wdata;
                A_NUM_HI: d.num[DIV_W-1:BUS_W] = wdata;
                A_DEN_LO: d.den[BUS_W-1:0]     = wdata;
                A_DEN_HI: d.den[DIV_W-1:BUS_W] = wdata;
                default: ;
            endcase
        end
        if (accept) begin
            d.quo  = res_quo;
            d.rem  = res_rem;
            d.err  = res_err;
            d.busy = 1'b0;
        end
        if (wr_start) begin
            d.busy  = 1'b1;
            d.start = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[1:0]      = q.mode;
        ctrl_word[ERR_BIT]  = q.err;
        ctrl_word[BUSY_BIT] = q.busy;
        case (addr)
            A_CTRL:   rdata = ctrl_word;
            A_NUM_LO: rdata = q.num[BUS_W-1:0];
            A_NUM_HI: rdata = q.num[DIV_W-1:BUS_W];
            A_DEN_LO: rdata = q.den[BUS_W-1:0];
            A_DEN_HI: rdata = q.den[DIV_W-1:BUS_W];
            A_QUO_LO: rdata = q.quo[BUS_W-1:0];
            A_QUO_HI: rdata = q.quo[DIV_W-1:BUS_W];
            A_REM_LO: rdata = q.rem[BUS_W-1:0];
            A_REM_HI: rdata = q.rem[DIV_W-1:BUS_W];
            default:  rdata = '0;
        endcase
    end

    // R2: a starting write raises busy on the next cycle
    p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr <= A_DEN_HI) |=> q.busy);

    // R9: results and flags stay frozen while idle with no write
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && !wr_en) |=> ($stable(q.quo) && $stable(q.rem) && $stable(q.err)));

    // R5: overflow capture keeps the old remainder and flags an error
    p_ovf_rem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && q.busy && !q.start && !wr_en && ovf && !den_zero)
        |=> (q.rem == $past(q.rem) && q.err && !q.busy));

    // R4: zero-divisor capture stores the effective dividend as remainder
    p_zero_den_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && q.busy && !q.start && !wr_en && den_zero)
        |=> (q.rem == $past(num_eff) && q.err));
endmodule

// File: tb/tb_sdiv_coproc.sv
`timescale 1ns/1ps
module tb_sdiv_coproc;
    localparam int W = 64;
    localparam longint LMIN = 64'sh8000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [63:0] quo;
        logic [63:0] rem;
        logic        err;
        logic        busy;
        string       tag;
    } item_t;

    item_t exp_q[$];
    item_t obs_q[$];
    longint model_rem = 0;

    sdiv_coproc #(.DIV_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata)
    );

    always #4 clk = ~clk;

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    function automatic void model(int mode, logic [63:0] nr, logic [63:0] dr,
                                  output logic [63:0] qo, output logic [63:0] ro,
                                  output logic eo);
        longint n, dd;
        n  = (mode == 0) ? longint'(int'(nr[31:0])) : longint'(nr);
        dd = (mode == 2) ? longint'(dr) : longint'(int'(dr[31:0]));
        if (dd == 0) begin
            qo = (n < 0) ? 64'd1 : 64'd0; ro = n; eo = 1'b1;
        end else if (n == LMIN && dd == -1) begin
            qo = n; ro = model_rem; eo = 1'b1;
        end else begin
            qo = n / dd; ro = n % dd; eo = 1'b0;
        end
        model_rem = longint'(ro);
    endfunction

    task automatic wait_done(output int n);
        logic [31:0] v;
        n = 0;
        forever begin
            rd(4'd0, v);
            if (!v[15]) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic collect(string tag);
        item_t o;
        logic [31:0] lo, hi, c;
        rd(4'd5, lo); rd(4'd6, hi); o.quo = {hi, lo};
        rd(4'd7, lo); rd(4'd8, hi); o.rem = {hi, lo};
        rd(4'd0, c); o.err = c[14]; o.busy = c[15];
        o.tag = tag;
        obs_q.push_back(o);
    endtask

    task automatic expect_op(int mode, logic [63:0] n, logic [63:0] dd, string tag);
        item_t e;
        model(mode, n, dd, e.quo, e.rem, e.err);
        e.busy = 1'b0; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic run_op(int mode, logic [63:0] n, logic [63:0] dd, string tag,
                          output int cyc);
        wr(4'd1, n[31:0]); wr(4'd2, n[63:32]);
        wr(4'd3, dd[31:0]); wr(4'd4, dd[63:32]);
        wr(4'd0, 32'(mode));
        expect_op(mode, n, dd, tag);
        wait_done(cyc);
        collect(tag);
    endtask

    // monitor: pairs observed results with the expected ones
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                item_t o, e;
                o = obs_q.pop_front();
                e = exp_q.pop_front();
                check({e.tag, " quotient"}, o.quo, e.quo);
                check({e.tag, " remainder"}, o.rem, e.rem);
                check({e.tag, " err flag R3"}, 64'(o.err), 64'(e.err));
                check({e.tag, " busy clear R2"}, 64'(o.busy), 64'(e.busy));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cyc;
        logic [31:0] v;
        logic [31:0] lo, hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state R2 R3 R7
        rd(4'd0, v);  check("R2 reset ctrl", 64'(v), 64'd0);
        rd(4'd5, lo); rd(4'd6, hi); check("R7 reset quotient", {hi, lo}, 64'd0);
        rd(4'd7, lo); rd(4'd8, hi); check("R7 reset remainder", {hi, lo}, 64'd0);

        // R1 R6 mode 0 signs
        run_op(0, 64'd100, 64'd7, "R6 m0 100/7", cyc);
        check("R10 busy length", 64'(cyc), 64'(W + 2));
        run_op(0, -64'sd100, 64'd7, "R6 m0 -100/7", cyc);
        run_op(0, 64'd100, -64'sd7, "R6 m0 100/-7", cyc);
        run_op(0, 64'hDEAD_BEEF_FFFF_FF9C, 64'h1234_5678_0000_0007, "R1 m0 upper ignored", cyc);
        run_op(0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R5 m0 narrow min/-1", cyc);

        // R1 modes 1, 3, 2
        run_op(1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_0000_1000, "R1 m1 narrow divisor", cyc);
        run_op(3, 64'hF123_4567_89AB_CDEF, 64'h7777_0000_FFFF_FF00, "R1 m3 narrow divisor", cyc);
        run_op(2, 64'hF123_4567_89AB_CDEF, 64'hFFFF_FFF0_0000_0001, "R1 m2 wide both", cyc);
        run_op(2, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0003_0000_0000, "R6 m2 large", cyc);

        // R7 operands read back as halves
        rd(4'd1, lo); rd(4'd2, hi); check("R7 dividend readback", {hi, lo}, 64'h7FFF_FFFF_FFFF_FFFF);
        rd(4'd3, lo); rd(4'd4, hi); check("R7 divisor readback", {hi, lo}, 64'h0000_0003_0000_0000);

        // R4 zero divisor
        run_op(2, 64'd12345, 64'd0, "R4 m2 zero positive", cyc);
        run_op(0, 64'h0000_0000_FFFF_FFF0, 64'hFFFF_FFFF_0000_0000, "R4 m0 zero negative", cyc);
        run_op(1, 64'h8000_0000_0000_0005, 64'hABCD_0000_0000_0000, "R4 m1 zero after extend", cyc);

        // R3 normal clears error
        run_op(2, 64'd81, 64'd9, "R3 normal clears error", cyc);

        // R5 overflow keeps old remainder
        run_op(2, 64'd83, 64'd9, "R5 set remainder", cyc);
        run_op(2, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R5 m2 overflow", cyc);
        run_op(1, 64'h8000_0000_0000_0000, 64'h0000_0000_FFFF_FFFF, "R5 m1 overflow", cyc);

        // R8 restart during a division
        wr(4'd1, 32'd1000); wr(4'd2, 32'd0); wr(4'd3, 32'd10); wr(4'd4, 32'd0);
        wr(4'd0, 32'd2);
        repeat (10) @(negedge clk);
        wr(4'd1, 32'd999);
        expect_op(2, 64'd999, 64'd10, "R8 restart");
        wait_done(cyc);
        collect("R8 restart");
        check("R8 restart busy length", 64'(cyc), 64'(W + 2));

        // R9 writes to result and unused addresses are ignored
        wr(4'd5, 32'hAAAA_AAAA); wr(4'd6, 32'h5555_5555);
        wr(4'd7, 32'h1234_0000); wr(4'd8, 32'h0000_4321); wr(4'd12, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(4'd0, v);  check("R9 no start", 64'(v[15]), 64'd0);
        rd(4'd5, lo); rd(4'd6, hi); check("R9 quotient kept", {hi, lo}, 64'd99);
        rd(4'd7, lo); rd(4'd8, hi); check("R9 remainder kept", {hi, lo}, 64'd9);
        rd(4'd12, v); check("R9 unused reads zero", 64'(v), 64'd0);

        repeat (4) @(negedge clk);
        check("scoreboard drained", 64'(exp_q.size() + obs_q.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule